// File: doc/BRIEF.md
# Serial Frame Transmitter Port

This block turns one packet into a single-bit serial frame on one channel. A command handshake supplies a 4-bit destination and a byte count. A second valid/ready handshake then supplies the payload bytes one at a time. On the serial side the block drives a data line, an active-low frame strobe and an active-low valid strobe.

Every frame goes through the same four phases in a fixed order. The first is an address phase that shifts out the destination, least significant bit first. The second is a fixed pad gap. The third is the payload, sent one bit per clock with each byte least significant bit first. The last is a single idle clock. The frame strobe stays low from the first address bit up to the final payload bit. It rises on that final bit, not after it. A busy flag is raised while a frame is in flight, and no second command is taken until the frame has finished.

The payload path holds one byte in a buffer ahead of the shifter. It asks for a byte only when that buffer is empty and the packet still needs bytes. A source that answers within a byte time therefore never causes a gap in the serial stream. If no byte is ready when the shifter needs one, a zero byte is sent in its place.

Top module: `sfx_tx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it: `ser_data` is 0, `ser_frame_n` and `ser_valid_n` are 1, `busy` and `byte_ready` are 0, and `cmd_ready` is 1.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. From the next cycle `busy` is 1 and `cmd_ready` is 0 until the frame has finished. A command offered meanwhile waits and is sent afterwards.
- R3: A frame opens when `ser_frame_n` falls. The first 4 clocks of frame low carry `cmd_dest`, bit 0 first, with `ser_valid_n` held at 1.
- R4: The 5 clocks after the address have `ser_data` = 1, `ser_valid_n` = 1 and `ser_frame_n` = 0.
- R5: The payload bytes follow, in the order they were accepted. Each byte takes 8 clocks, bit 0 first, with `ser_valid_n` = 0 on every payload bit. The stream has no gap as long as each byte is offered within 8 clocks of `byte_ready` rising.
- R6: `ser_frame_n` stays 0 on every payload bit except bit 7 of the last byte, where it is 1 while `ser_valid_n` is still 0.
- R7: The clock after the last payload bit has `ser_data` = 0 and both strobes at 1.
- R8: `cmd_len` is sampled only on the accepting edge. A value of 0 sends one byte, and a value above MAX_LEN (32) sends MAX_LEN bytes. Changing `cmd_len` after acceptance has no effect.
- R9: `byte_ready` is 1 only while a frame is in flight, the one-byte buffer is empty and the packet still needs bytes. Exactly the packet's byte count is taken, and bytes offered while idle are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (channel idle) |
| cmd_dest | input | 4 | Destination address |
| cmd_len | input | 6 | Payload byte count (0 treated as 1, clamped to 32) |
| byte_valid | input | 1 | Payload byte offered |
| byte_ready | output | 1 | Payload byte wanted |
| byte_data | input | 8 | Payload byte |
| ser_data | output | 1 | Serial data line |
| ser_frame_n | output | 1 | Active-low frame strobe |
| ser_valid_n | output | 1 | Active-low payload-valid strobe |
| busy | output | 1 | Frame in flight on this channel |

## Verification
The bench decodes each frame from the serial lines and compares it with the packet queued by the driver.

- Single-byte and maximum-length packets expose a design that raises the frame strobe one clock late or on the wrong byte. Such a design would either close the frame after the idle clock or truncate the payload.
- A zero count and an oversized count catch a design that sends nothing, or that wraps the count instead of clamping it.
- Rewriting `cmd_len` right after acceptance catches a design that reads the count late.
- Back-to-back commands catch a design that accepts a command mid-frame and so corrupts the running frame.
- Bytes offered while idle catch a design that takes a byte it should not. Such a design would shift every later payload by one byte.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_PAD  = 3'd2,
    PH_DATA = 3'd3,
    PH_TAIL = 3'd4
  } sfx_phase_e;
endpackage

// File: rtl/sfx_len_norm.sv
module sfx_len_norm #(
  parameter int LEN_W   = 6,
  parameter int MAX_LEN = 32,
  parameter int IDX_W   = 5
) (
  input  logic [LEN_W-1:0] raw_len,
  output logic [IDX_W-1:0] last_idx
);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_LEN);

  always_comb begin
    if (raw_len == '0)
      last_idx = '0;
    else if (raw_len > LIM)
      last_idx = IDX_W'(MAX_LEN - 1);
    else
      last_idx = IDX_W'(raw_len - 1'b1);
  end
endmodule

// File: rtl/sfx_seq.sv
module sfx_seq
  import sfx_pkg::*;
#(
  parameter int DEST_W   = 4,
  parameter int IDX_W    = 5,
  parameter int PAD_CLKS = 5,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fire,
  input  logic [DEST_W-1:0] dest_in,
  input  logic [IDX_W-1:0]  last_in,
  output sfx_phase_e        phase,
  output logic [IDX_W-1:0]  last_idx,
  output logic              addr_bit,
  output logic              load,
  output logic              frame_last
);
  localparam int CMAX_A  = (DEST_W > PAD_CLKS) ? DEST_W : PAD_CLKS;
  localparam int CNT_MAX = (CMAX_A > BYTE_W) ? CMAX_A : BYTE_W;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(DEST_W - 1);
  localparam logic [CNT_W-1:0] PAD_END  = CNT_W'(PAD_CLKS - 1);
  localparam logic [CNT_W-1:0] BIT_END  = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [DEST_W-1:0] dest_q;
  logic [DEST_W-1:0] dest_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      byte_idx <= '0;
      dest_q   <= '0;
      last_idx <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (cmd_fire) begin
          phase    <= PH_ADDR;
          cnt      <= '0;
          byte_idx <= '0;
          dest_q   <= dest_in;
          last_idx <= last_in;
        end
        PH_ADDR: if (cnt == ADDR_END) begin
          phase <= PH_PAD;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_PAD: if (cnt == PAD_END) begin
          phase <= PH_DATA;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_DATA: if (cnt == BIT_END) begin
          cnt <= '0;
          if (byte_idx == last_idx) phase <= PH_TAIL;
          else byte_idx <= byte_idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        PH_TAIL: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    dest_sh    = dest_q >> cnt;
    addr_bit   = dest_sh[0];
    load       = ((phase == PH_PAD) && (cnt == PAD_END)) ||
                 ((phase == PH_DATA) && (cnt == BIT_END) && (byte_idx != last_idx));
    frame_last = (phase == PH_DATA) && (cnt == BIT_END) && (byte_idx == last_idx);
  end

  // R4
  pad_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAD) |-> (cnt <= PAD_END));
endmodule

// File: rtl/sfx_feed.sv
module sfx_feed #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fire,
  input  logic              active,
  input  logic              shift_en,
  input  logic              load,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              tx_bit
);
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] shift_q;
  logic              hold_full;
  logic [IDX_W:0]    req_cnt;
  logic              more;
  logic              byte_fire;

  assign more       = (req_cnt <= {1'b0, last_idx});
  assign byte_ready = active && !hold_full && more;
  assign byte_fire  = byte_valid && byte_ready;
  assign tx_bit     = shift_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      shift_q   <= '0;
      hold_full <= 1'b0;
      req_cnt   <= '0;
    end else if (cmd_fire) begin
      hold_full <= 1'b0;
      req_cnt   <= '0;
    end else if (load) begin
      if (hold_full) begin
        shift_q   <= hold_q;
        hold_full <= 1'b0;
      end else if (byte_fire) begin
        shift_q <= byte_data;
        req_cnt <= req_cnt + 1'b1;
      end else begin
        shift_q <= '0;
        if (more) req_cnt <= req_cnt + 1'b1;
      end
    end else begin
      if (shift_en) shift_q <= shift_q >> 1;
      if (byte_fire) begin
        hold_q    <= byte_data;
        hold_full <= 1'b1;
        req_cnt   <= req_cnt + 1'b1;
      end
    end
  end

  // R9
  take_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_fire && !cmd_fire) |=> (req_cnt <= {1'b0, last_idx} + 1'b1));
endmodule

// File: rtl/sfx_line.sv
module sfx_line
  import sfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sfx_phase_e phase,
  input  logic       addr_bit,
  input  logic       tx_bit,
  input  logic       frame_last,
  output logic       ser_data,
  output logic       ser_frame_n,
  output logic       ser_valid_n
);
  logic d_nx, f_nx, v_nx;

  always_comb begin
    case (phase)
      PH_ADDR: begin d_nx = addr_bit; f_nx = 1'b0;       v_nx = 1'b1; end
      PH_PAD:  begin d_nx = 1'b1;     f_nx = 1'b0;       v_nx = 1'b1; end
      PH_DATA: begin d_nx = tx_bit;   f_nx = frame_last; v_nx = 1'b0; end
      default: begin d_nx = 1'b0;     f_nx = 1'b1;       v_nx = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data    <= 1'b0;
      ser_frame_n <= 1'b1;
      ser_valid_n <= 1'b1;
    end else begin
      ser_data    <= d_nx;
      ser_frame_n <= f_nx;
      ser_valid_n <= v_nx;
    end
  end

  // R3
  open_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_frame_n) |-> ser_valid_n);
  // R6
  close_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_frame_n) |-> !ser_valid_n);
  // R7
  idle_after_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_frame_n) |=> (ser_valid_n && ser_frame_n && !ser_data));
  // R5
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (!ser_valid_n && ser_frame_n) |=> ser_valid_n);
endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int DEST_W   = 4,
  parameter int MAX_LEN  = 32,
  parameter int BYTE_W   = 8,
  parameter int PAD_CLKS = 5,
  parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DEST_W-1:0] cmd_dest,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              ser_data,
  output logic              ser_frame_n,
  output logic              ser_valid_n,
  output logic              busy
);
  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  sfx_phase_e       phase;
  logic [IDX_W-1:0] last_in, last_idx;
  logic             addr_bit, load, frame_last, tx_bit, cmd_fire, active;

  assign cmd_ready = (phase == PH_IDLE);
  assign busy      = (phase != PH_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign active    = (phase == PH_ADDR) || (phase == PH_PAD) || (phase == PH_DATA);

  sfx_len_norm #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_len (
    .raw_len(cmd_len), .last_idx(last_in));

  sfx_seq #(.DEST_W(DEST_W), .IDX_W(IDX_W), .PAD_CLKS(PAD_CLKS), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .dest_in(cmd_dest), .last_in(last_in),
    .phase(phase), .last_idx(last_idx), .addr_bit(addr_bit), .load(load),
    .frame_last(frame_last));

  sfx_feed #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_feed (
    .clk(clk), .rst(rst), .cmd_fire(cmd_fire), .active(active),
    .shift_en(phase == PH_DATA), .load(load), .last_idx(last_idx),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .tx_bit(tx_bit));

  sfx_line u_line (
    .clk(clk), .rst(rst), .phase(phase), .addr_bit(addr_bit), .tx_bit(tx_bit),
    .frame_last(frame_last), .ser_data(ser_data), .ser_frame_n(ser_frame_n),
    .ser_valid_n(ser_valid_n));

  // R2
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> (busy && !cmd_ready));
endmodule

// File: tb/sim_sfx_tx.sv
`timescale 1ns/1ps
module sim_sfx_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_dest = '0;
  logic [5:0] cmd_len = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       cmd_ready, byte_ready, ser_data, ser_frame_n, ser_valid_n, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_busy = 1'b0;
  logic [3:0] dest_q[$];
  int         len_q[$];
  logic [7:0] byte_q[$];

  always #10 clk = ~clk;

  sfx_tx u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dest(cmd_dest), .cmd_len(cmd_len), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .ser_data(ser_data),
    .ser_frame_n(ser_frame_n), .ser_valid_n(ser_valid_n), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [3:0] d, input int lin, input logic [7:0] base,
                          input int gap, input int poke);
    int n;
    n = (lin == 0) ? 1 : ((lin > 32) ? 32 : lin);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dest = d; cmd_len = 6'(lin);
    while (!cmd_ready) begin
      chk(busy, "R2 wait while busy", busy, 1);
      @(negedge clk);
    end
    dest_q.push_back(d);
    len_q.push_back(n);
    for (int i = 0; i < n; i++) byte_q.push_back(base + 8'(i));
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_len = 6'(poke);
    chk(busy && !cmd_ready, "R2 busy after accept", {busy, cmd_ready}, 2);
    for (int i = 0; i < n; i++) begin
      repeat (gap) @(negedge clk);
      byte_valid = 1'b1; byte_data = base + 8'(i);
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
      byte_valid = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!byte_ready, "R9 no request after last byte", byte_ready, 0);
  endtask

  // monitor: decode each frame from the serial lines and compare
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !ser_frame_n) begin
        logic [3:0] d;
        logic [7:0] b;
        int n, cnt;
        bit abad, pbad, vbad, fbad, done;
        mon_busy = 1'b1;
        abad = 0; pbad = 0; vbad = 0; fbad = 0; done = 0; cnt = 0;
        for (int i = 0; i < 4; i++) begin
          if (i > 0) @(negedge clk);
          d[i] = ser_data;
          if (!ser_valid_n || ser_frame_n) abad = 1;
        end
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          if (!ser_data || !ser_valid_n || ser_frame_n) pbad = 1;
        end
        if (dest_q.size() == 0) begin
          chk(0, "R2 frame without command", 0, 1);
          n = 0;
        end else begin
          chk(d == dest_q[0], "R3 destination", d, dest_q[0]);
          void'(dest_q.pop_front());
          n = len_q.pop_front();
        end
        chk(!abad, "R3 address strobes", abad, 0);
        chk(!pbad, "R4 pad clocks", pbad, 0);
        while (!done && cnt < 40) begin
          for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            b[k] = ser_data;
            if (ser_valid_n) vbad = 1;
            if (k < 7 && ser_frame_n) fbad = 1;
            if (k == 7) done = ser_frame_n;
          end
          if (cnt < n) begin
            chk(b == byte_q[0], "R5 payload byte", b, byte_q[0]);
            void'(byte_q.pop_front());
          end
          if (!done && cnt == n - 1) fbad = 1;
          cnt++;
        end
        chk(cnt == n, "R8 byte count", cnt, n);
        chk(!vbad, "R5 valid low on payload", vbad, 0);
        chk(!fbad, "R6 frame release on last bit", fbad, 0);
        @(negedge clk);
        chk(!ser_data && ser_valid_n && ser_frame_n, "R7 idle clock",
            {ser_data, ser_valid_n, ser_frame_n}, 3);
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  task automatic drain();
    repeat (2) @(negedge clk);
    while (busy || mon_busy || dest_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!ser_data && ser_frame_n && ser_valid_n, "R1 reset lines",
        {ser_data, ser_frame_n, ser_valid_n}, 3);
    chk(!busy && !byte_ready && cmd_ready, "R1 reset handshakes",
        {busy, byte_ready, cmd_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!ser_data && ser_frame_n && ser_valid_n && !busy, "R1 after reset",
        {ser_data, ser_frame_n, ser_valid_n, busy}, 6);

    send_pkt(4'h5, 3, 8'h50, 0, 3);
    drain();
    send_pkt(4'hA, 1, 8'hA0, 2, 1);
    drain();
    send_pkt(4'h6, 0, 8'h60, 1, 20);   // R8 zero count, late rewrite
    drain();
    send_pkt(4'hF, 40, 8'hC0, 1, 40);  // R8 clamp to 32
    drain();
    send_pkt(4'h3, 2, 8'h30, 0, 2);    // R2 back to back
    send_pkt(4'hC, 4, 8'hE0, 3, 9);
    drain();

    // R9 bytes offered while idle are not taken
    byte_valid = 1'b1; byte_data = 8'hEE;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!byte_ready, "R9 idle byte refused", byte_ready, 0);
    end
    byte_valid = 1'b0;
    send_pkt(4'h9, 2, 8'h90, 0, 2);
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule